// File: doc/BRIEF.md
# Sensitivity-Configurable Interrupt Line Controller

This block gathers a bank of asynchronous interrupt request wires (32 by default) and merges them into one interrupt wire toward a parent controller. Each wire passes through a two-flop synchroniser. Two configuration bits per line then decide how it is sensed. One bit chooses between level and transition sensing. The other chooses the active sense: high or rising, versus low or falling. The result lands in a per-line status bit.

Software reaches the block through a plain register port: one write strobe, a byte address and a data word. Reads are combinational from the same address. Software can mask or unmask each line, acknowledge latched transitions with write-one-to-clear, and raise a line by hand with write-one-to-set. The merged output is a registered OR of every status bit whose enable bit is also set.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset the enable mask is 0, all status bits are 0, the edge-select register is 0, the polarity register is all ones, and `irq_out` is 0.
- R2: The byte offsets are: 0x00 status (read-only), 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity, 0x14 edge-select. Bit i of each register refers to line i. The set and clear offsets read as 0. Any other offset reads as 0, and writes to it change nothing.
- R3: The inputs are synchronised by two flops. A level change driven between clock edges shows in the status register after the third rising edge, and not after the second.
- R4: With edge=0 and polarity=1, a line's status bit follows the synchronised input (active-high level).
- R5: With edge=0 and polarity=0, a line's status bit follows the inverse of the synchronised input (active-low level).
- R6: With edge=1 and polarity=1, a 0-to-1 transition sets the status bit. The bit stays set after the input returns low, until it is cleared.
- R7: With edge=1 and polarity=0, a 1-to-0 transition sets the status bit and it is held in the same way.
- R8: Writing 1 to a clear bit drops a latched transition-mode status bit on that write's edge. If a transition is detected on the same edge as the clear, the bit stays set. In level mode, clear has no effect while the level is active.
- R9: Writing 1 to a set bit makes that status bit 1 on the write's edge. In transition mode it then holds until cleared. In level mode it lasts one cycle and then follows the input again.
- R10: `irq_out` is 1 exactly when, on the previous edge, some line had both its status bit and its enable bit set. Clearing an enable bit drops its contribution one cycle later and leaves the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_LINES | Asynchronous interrupt request inputs |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Registered merged interrupt toward the parent |

## Verification
On every cycle, the embedded properties check four things: that the merged output tracks the previous cycle's masked status; that a set strobe always leaves its bit at 1; that a latched transition bit survives any cycle without a clear; and that a level-mode bit mirrors the polarity-adjusted input. They also check that writes to unmapped offsets leave the configuration untouched. Only the bench's scenarios can show the end-to-end effects, because those cross the synchroniser and the bus. These are the three-edge input latency, the rising and falling transitions that actually latch, mixed per-line sensitivities within one word, the clear colliding with a fresh transition, and the one-cycle life of a software set in level mode.

// File: rtl/irqc_pkg.sv
// Package: shared register offsets for the interrupt line controller.
// Assumes byte addressing with word-aligned registers.
package irqc_pkg;
    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_ENABLE = 8'h04;
    localparam logic [7:0] OFS_SET    = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_POL    = 8'h10;
    localparam logic [7:0] OFS_EDGE   = 8'h14;
    localparam logic [7:0] OFS_LAST   = OFS_EDGE;
endpackage

// File: rtl/irqc_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages resolve metastability one more cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_line_cell.sv
// Module: one interrupt line's sensing and status bit.
// Assumes smp_i is already synchronised. A set strobe wins over all else.
// In transition mode a detected transition wins over a clear. In level mode
// the bit mirrors the active level.
module irqc_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic edge_i,
    input  logic pol_i,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);
    logic prev_q;
    logic status_q;
    logic active;
    logic hit;

    // Polarity-adjusted level and selected transition detect.
    always_comb begin
        active = pol_i ? smp_i : ~smp_i;
        hit    = pol_i ? (smp_i & ~prev_q) : (~smp_i & prev_q);
    end

    // Remember the previous synchronised sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    // Status update: set, then transition latch or level follow.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= 1'b0;
        else if (set_i)  status_q <= 1'b1;
        else if (edge_i) status_q <= hit | (status_q & ~clr_i);
        else             status_q <= active;
    end

    assign status_o = status_q;

    // R9
    set_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> status_q);

    // R6
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && status_q && !clr_i) |=> status_q);

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !set_i) |=>
            (status_q == ($past(pol_i) ? $past(smp_i) : !$past(smp_i))));
endmodule

// File: rtl/irqc_regbank.sv
// Module: configuration registers, write strobes and read multiplexer.
// Assumes a single write per cycle; reads are combinational from addr_i.
module irqc_regbank
    import irqc_pkg::*;
#(
    parameter int NL = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NL-1:0] wdata_i,
    input  logic [NL-1:0] status_i,
    output logic [NL-1:0] rdata_o,
    output logic [NL-1:0] enable_o,
    output logic [NL-1:0] pol_o,
    output logic [NL-1:0] edge_o,
    output logic [NL-1:0] set_o,
    output logic [NL-1:0] clr_o
);
    localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
    localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_SET    = AW'(OFS_SET);
    localparam logic [AW-1:0] A_CLEAR  = AW'(OFS_CLEAR);
    localparam logic [AW-1:0] A_POL    = AW'(OFS_POL);
    localparam logic [AW-1:0] A_EDGE   = AW'(OFS_EDGE);

    logic [NL-1:0] enable_q, pol_q, edge_q;
    logic          mapped;

    // Decode whether the current address hits a defined register.
    always_comb begin
        mapped = (addr_i == A_STATUS) || (addr_i == A_ENABLE) ||
                 (addr_i == A_SET)    || (addr_i == A_CLEAR)  ||
                 (addr_i == A_POL)    || (addr_i == A_EDGE);
    end

    // Configuration register writes with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            pol_q    <= '1;
            edge_q   <= '0;
        end else if (wr_i) begin
            if (addr_i == A_ENABLE) enable_q <= wdata_i;
            if (addr_i == A_POL)    pol_q    <= wdata_i;
            if (addr_i == A_EDGE)   edge_q   <= wdata_i;
        end
    end

    // One-cycle set and clear strobes derived from the write.
    always_comb begin
        set_o = (wr_i && addr_i == A_SET)   ? wdata_i : '0;
        clr_o = (wr_i && addr_i == A_CLEAR) ? wdata_i : '0;
    end

    // Read multiplexer; strobe and unmapped offsets return zero.
    always_comb begin
        case (addr_i)
            A_STATUS: rdata_o = status_i;
            A_ENABLE: rdata_o = enable_q;
            A_POL:    rdata_o = pol_q;
            A_EDGE:   rdata_o = edge_q;
            default:  rdata_o = '0;
        endcase
    end

    assign enable_o = enable_q;
    assign pol_o    = pol_q;
    assign edge_o   = edge_q;

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !mapped) |=>
            ($stable(enable_q) && $stable(pol_q) && $stable(edge_q)));
endmodule

// File: rtl/irq_line_ctrl.sv
// Module: top of the interrupt line controller. Synchronises the request
// lines, senses each one per its configuration, and drives one registered
// merged interrupt. Assumes NUM_LINES does not exceed the bus data width.
module irq_line_ctrl #(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] smp, status, enable, pol, edge_sel, set_stb, clr_stb;
    logic                 irq_q;

    irqc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines),
        .sync_o  (smp)
    );

    irqc_regbank #(.NL(NUM_LINES), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .status_i (status),
        .rdata_o  (bus_rdata),
        .enable_o (enable),
        .pol_o    (pol),
        .edge_o   (edge_sel),
        .set_o    (set_stb),
        .clr_o    (clr_stb)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            irqc_line_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .smp_i    (smp[i]),
                .edge_i   (edge_sel[i]),
                .pol_i    (pol[i]),
                .set_i    (set_stb[i]),
                .clr_i    (clr_stb[i]),
                .status_o (status[i])
            );
        end
    endgenerate

    // Register the OR of the masked status toward the parent controller.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & enable);
    end

    assign irq_out = irq_q;

    // R10
    merged_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(status & enable)));
endmodule

// File: tb/irq_line_ctrl_test.sv
`timescale 1ns/1ps
module irq_line_ctrl_test;
    localparam int NL = 32;
    localparam int AW = 8;

    typedef struct packed {
        logic [31:0] edg;
        logic [31:0] pol;
        logic [31:0] pre;
        logic [31:0] post;
        logic [31:0] exp;
    } vec_t;

    // Sensitivity vectors: config, input before clear, input after, expected status.
    localparam vec_t VECS [5] = '{
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h00FF_00FF, 32'h00FF_0000},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 32'h00FF_00FF, 32'h0000_FF00},
        '{32'h0000_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h3333_3333, 32'hCC33_0C30}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_lines = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NL-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_rdata;
    logic          irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_line_ctrl #(.NUM_LINES(NL), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic restore();
        irq_lines = '0;
        bus_write(8'h14, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'h0);
        idle(5);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        idle(1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values, R2 strobe offsets read as zero
        bus_read(8'h00, d); check("R1 status", d, 32'h0);
        bus_read(8'h04, d); check("R1 enable", d, 32'h0);
        bus_read(8'h10, d); check("R1 polarity", d, 32'hFFFF_FFFF);
        bus_read(8'h14, d); check("R1 edge", d, 32'h0);
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        bus_read(8'h08, d); check("R2 set reads 0", d, 32'h0);
        bus_read(8'h0C, d); check("R2 clear reads 0", d, 32'h0);

        // R2 unmapped offset: write ignored, reads 0, mapped regs intact
        bus_write(8'h18, 32'hDEAD_BEEF);
        bus_write(8'h05, 32'hFFFF_FFFF);
        bus_read(8'h18, d); check("R2 unmapped read", d, 32'h0);
        bus_read(8'h04, d); check("R2 enable untouched", d, 32'h0);
        bus_read(8'h14, d); check("R2 edge untouched", d, 32'h0);

        // R3 synchroniser latency: visible after third edge only
        @(negedge clk); irq_lines[3] = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1; bus_read(8'h00, d); check("R3 after 2 edges", d & 32'h8, 32'h0);
        @(posedge clk); #1; bus_read(8'h00, d); check("R3 after 3 edges", d & 32'h8, 32'h8);
        restore();

        // R4 R5 R6 R7 vector table
        foreach (VECS[v]) begin
            bus_write(8'h14, VECS[v].edg);
            bus_write(8'h10, VECS[v].pol);
            irq_lines = VECS[v].pre;
            idle(6);
            bus_write(8'h0C, 32'hFFFF_FFFF);
            idle(2);
            irq_lines = VECS[v].post;
            idle(6);
            bus_read(8'h00, d);
            check($sformatf("R4 R5 R6 R7 vector %0d", v), d, VECS[v].exp);
        end
        restore();

        // R6 rising latch holds after input drops, then clears (R8)
        bus_write(8'h14, 32'h0000_0200);
        @(negedge clk); irq_lines[9] = 1'b1;
        idle(5);
        irq_lines[9] = 1'b0;
        idle(6);
        bus_read(8'h00, d); check("R6 held after drop", d, 32'h0000_0200);
        bus_write(8'h0C, 32'h0000_0200);
        bus_read(8'h00, d); check("R8 clear latched", d, 32'h0);

        // R8 clear on same edge as a fresh rising transition keeps the bit
        bus_write(8'h14, 32'h0000_0080);
        @(negedge clk); irq_lines[7] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0080;
        @(posedge clk); #1; bus_wr = 1'b0;
        bus_read(8'h00, d); check("R8 transition beats clear", d & 32'h80, 32'h80);
        restore();

        // R8 clear ignored for an active level
        irq_lines[2] = 1'b1;
        idle(5);
        bus_write(8'h0C, 32'h0000_0004);
        bus_read(8'h00, d); check("R8 level clear no effect", d, 32'h0000_0004);
        restore();

        // R9 software set in level mode lasts one cycle
        bus_write(8'h08, 32'h0000_0800);
        bus_read(8'h00, d); check("R9 level set pulse", d, 32'h0000_0800);
        @(posedge clk); #1;
        bus_read(8'h00, d); check("R9 level set released", d, 32'h0);

        // R9 R10 software set in transition mode, output one cycle later
        bus_write(8'h14, 32'h0000_0020);
        bus_write(8'h04, 32'h0000_0020);
        bus_write(8'h08, 32'h0000_0020);
        bus_read(8'h00, d); check("R9 edge set", d, 32'h0000_0020);
        check("R10 irq_out not yet", {31'b0, irq_out}, 32'h0);
        @(posedge clk); #1;
        check("R10 irq_out raised", {31'b0, irq_out}, 32'h1);
        idle(3);
        bus_read(8'h00, d); check("R9 edge set holds", d, 32'h0000_0020);

        // R10 masking drops output, status retained
        bus_write(8'h04, 32'h0);
        check("R10 mask lag", {31'b0, irq_out}, 32'h1);
        @(posedge clk); #1;
        check("R10 masked output", {31'b0, irq_out}, 32'h0);
        bus_read(8'h00, d); check("R10 status kept", d, 32'h0000_0020);

        // R10 unmask then acknowledge lowers output
        bus_write(8'h04, 32'h0000_0020);
        idle(1);
        check("R10 unmasked output", {31'b0, irq_out}, 32'h1);
        bus_write(8'h0C, 32'h0000_0020);
        @(posedge clk); #1;
        check("R10 acked output", {31'b0, irq_out}, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule